// File: doc/BRIEF.md
# Back-to-Back Aware Bus Target Tracker

This block is the bus-side tracking and claim logic for one target on a shared, multiplexed address/data bus with active-low framing and handshake lines. It watches every transaction on the bus, including those meant for other agents. It spots each address phase, even one that follows a final data transfer with no Idle cycle between them. It decodes a parameterised address window at that same clock edge and claims hits by driving DEVSEL# together with TRDY# (or STOP# for a Retry), behind a shared output enable.

A zero-wait-state claim could collide with the previous target's turnaround. The block therefore adds a single clock of hold before it drives, but only in one case: the address phase came straight after a final data transfer, and this target did not own the transaction that just ended. After the last data phase it drives its response lines high for one clock and then releases them. Two constant status outputs report fast decode timing and support for back-to-back target operation.

Top module: `fb2b_target_trk`

## Requirements
- R1: A sampled FRAME# low, when FRAME# was high at the previous edge, is an address phase. This includes the case where the previous edge saw FRAME# high with IRDY# low. The AD value is captured into `addr_q` at that edge. `addr_seen` is high for the following cycle, and `b2b_seen` is also high when the previous edge saw IRDY# low.
- R2: Transactions that miss the window are tracked too. `trk_busy` rises after their address phase and `addr_seen` pulses.
- R3: A hit whose address phase followed an Idle cycle (FRAME# and IRDY# both high) is claimed at once. In the cycle after the address phase, `resp_oe`=1, `devsel_o_n`=0, and TRDY# or STOP# is asserted.
- R4: A hit that follows a final data transfer directly, after a transaction this target did not claim, gets one cycle with `resp_oe`=0 and all response lines high. The claim comes in the next cycle.
- R5: A hit that follows a final data transfer directly, after a transaction this target claimed, is claimed with no hold cycle.
- R6: The record of whether this target claimed the previous transaction is replaced at every address phase and cleared by any Idle cycle. A claim therefore does not carry over an intervening transaction to another agent.
- R7: The last data phase ends at an edge that sees FRAME# high, IRDY# low and this target's TRDY# or STOP# low. After it, DEVSEL#, TRDY# and STOP# are driven high for one cycle with `resp_oe`=1, and `resp_oe` then drops. While FRAME# stays low, the claim is held.
- R8: With `retry_req`=1 at the address phase, a claim asserts DEVSEL# and STOP# (0) with TRDY# high (1). TRDY# and STOP# are never low together.
- R9: While tracking a foreign transaction, `trk_busy` falls after the edge that sees FRAME# high or the bus DEVSEL# low, without waiting for IRDY#.
- R10: `stat_fb2b_cap` is 1 and `stat_devsel_speed` is 2'b00 (fast), including while a claim is held off.
- R11: A miss never raises `resp_oe`.
- R12: Under reset, and at the first edge after it, `resp_oe`=0, all response lines are high, and `trk_busy`, `addr_seen` and `b2b_seen` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Bus FRAME#, sampled |
| irdy_n | input | 1 | Bus IRDY#, sampled |
| devsel_n_in | input | 1 | Bus DEVSEL# as seen on the wire |
| ad | input | AW | Multiplexed address/data bus |
| retry_req | input | 1 | Back end asks for Retry, sampled at the address phase |
| devsel_o_n | output | 1 | DEVSEL# drive value |
| trdy_o_n | output | 1 | TRDY# drive value |
| stop_o_n | output | 1 | STOP# drive value |
| resp_oe | output | 1 | Shared output enable for the three response lines |
| trk_busy | output | 1 | Tracker not idle |
| addr_seen | output | 1 | Pulse: an address phase was sampled at the last edge |
| b2b_seen | output | 1 | Pulse: that address phase had no Idle cycle before it |
| addr_q | output | AW | Address captured at the last address phase |
| stat_fb2b_cap | output | 1 | Back-to-back capable status, constant 1 |
| stat_devsel_speed | output | 2 | Decode speed code, constant 2'b00 |

## Verification
Every result is registered. A bus cycle's effect therefore shows in the cycle after the edge that samples it, with one exception: a held-off claim appears one cycle later still. The bench changes inputs on the falling edge, lets one rising edge pass, and compares on the next falling edge. Each table row therefore holds the outputs due right after its own inputs are sampled, and the hold cycle of R4 occupies a row of its own. The turnaround and release of R7 span two consecutive rows, so both cycles are checked separately.

// File: rtl/fb2b_pkg.sv
// Shared types for the back-to-back aware target tracker.
package fb2b_pkg;
    // Claim state machine encoding; order carries no meaning.
    typedef enum logic [2:0] {
        ST_IDLE,   // no transaction in progress
        ST_BUSY,   // following a transaction owned by someone else
        ST_WAIT,   // hit, holding off one clock for turnaround safety
        ST_DATA,   // claimed, response lines driven low as needed
        ST_TURN    // final phase done, lines driven high before release
    } trk_state_e;

    // Decode speed code reported in status: fast.
    localparam logic [1:0] DEVSEL_SPEED_FAST = 2'b00;
endpackage

// File: rtl/fb2b_addr_dec.sv
// Address window comparator.
// Does: flags a hit when every AD bit selected by WIN_MASK equals WIN_BASE.
// Assumes: purely combinational; the caller qualifies it with the address phase.
module fb2b_addr_dec #(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] WIN_BASE = '0,
    parameter logic [AW-1:0] WIN_MASK = '0
) (
    input  logic [AW-1:0] ad,
    output logic          hit
);
    logic [AW-1:0] bit_ok;

    // Per-bit match, don't-care where the mask is clear.
    generate
        for (genvar g = 0; g < AW; g++) begin : g_bit
            assign bit_ok[g] = !WIN_MASK[g] || (ad[g] == WIN_BASE[g]);
        end
    endgenerate

    assign hit = &bit_ok;
endmodule

// File: rtl/fb2b_phase_trk.sv
// Bus phase tracker.
// Does: remembers the previous sampled FRAME#/IRDY#, marks address phases
// (including those right after a final data transfer), captures the address
// and keeps the "claimed previous transaction" flag.
// Assumes: inputs are sampled bus lines; synchronous active-low reset.
module fb2b_phase_trk #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_n,
    input  logic          irdy_n,
    input  logic [AW-1:0] ad,
    input  logic          hit,
    output logic          addr_phase,
    output logic          fb2b,
    output logic          claimed_last,
    output logic [AW-1:0] addr_q,
    output logic          addr_seen,
    output logic          b2b_seen
);
    logic prev_frame_n;
    logic prev_irdy_n;
    logic bus_idle;

    assign addr_phase = !frame_n && prev_frame_n;
    assign fb2b       = addr_phase && !prev_irdy_n;
    assign bus_idle   = frame_n && irdy_n;

    // Purpose: keep last sampled framing lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_frame_n <= 1'b1;
            prev_irdy_n  <= 1'b1;
        end else begin
            prev_frame_n <= frame_n;
            prev_irdy_n  <= irdy_n;
        end
    end

    // Purpose: record whether the latest transaction was ours.
    always_ff @(posedge clk) begin
        if (!rst_n)          claimed_last <= 1'b0;
        else if (addr_phase) claimed_last <= hit;
        else if (bus_idle)   claimed_last <= 1'b0;
    end

    // Purpose: capture address and flag the phase for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            addr_seen <= 1'b0;
            b2b_seen  <= 1'b0;
        end else begin
            addr_seen <= addr_phase;
            b2b_seen  <= fb2b;
            if (addr_phase) addr_q <= ad;
        end
    end

    // R1
    addr_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && $past(frame_n)) |=> addr_seen);

    // R6
    idle_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_n && irdy_n) |=> !claimed_last);
endmodule

// File: rtl/fb2b_resp_fsm.sv
// Claim and response state machine.
// Does: claims hits with zero-wait decode, holds off one clock when a
// back-to-back start follows someone else's transaction, drives the
// turnaround, and leaves foreign transactions early.
// Assumes: addr_phase/fb2b/claimed_last come from the phase tracker of the
// same edge; devsel_n_in is the wired bus line.
module fb2b_resp_fsm
    import fb2b_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic devsel_n_in,
    input  logic addr_phase,
    input  logic hit,
    input  logic fb2b,
    input  logic claimed_last,
    input  logic retry_req,
    output logic devsel_o_n,
    output logic trdy_o_n,
    output logic stop_o_n,
    output logic resp_oe,
    output logic busy
);
    trk_state_e st_q, st_d;
    logic dev_q, dev_d, trdy_q, trdy_d, stop_q, stop_d;
    logic oe_q, oe_d, rty_q, rty_d;
    logic need_delay;
    logic last_done;

    assign need_delay = fb2b && !claimed_last;
    assign last_done  = frame_n && !irdy_n && (!trdy_q || !stop_q);

    // Purpose: next state and next drive values.
    always_comb begin
        st_d   = st_q;
        dev_d  = dev_q;
        trdy_d = trdy_q;
        stop_d = stop_q;
        oe_d   = oe_q;
        rty_d  = rty_q;
        case (st_q)
            ST_IDLE, ST_TURN: begin
                st_d   = ST_IDLE;
                oe_d   = 1'b0;
                dev_d  = 1'b1;
                trdy_d = 1'b1;
                stop_d = 1'b1;
                if (addr_phase) begin
                    rty_d = retry_req;
                    if (hit && !need_delay) begin
                        st_d   = ST_DATA;
                        oe_d   = 1'b1;
                        dev_d  = 1'b0;
                        trdy_d = retry_req;
                        stop_d = !retry_req;
                    end else if (hit) begin
                        st_d = ST_WAIT;
                    end else begin
                        st_d = ST_BUSY;
                    end
                end
            end
            ST_BUSY: begin
                if (frame_n || !devsel_n_in) st_d = ST_IDLE;
            end
            ST_WAIT: begin
                st_d   = ST_DATA;
                oe_d   = 1'b1;
                dev_d  = 1'b0;
                trdy_d = rty_q;
                stop_d = !rty_q;
            end
            ST_DATA: begin
                if (last_done) begin
                    st_d   = ST_TURN;
                    dev_d  = 1'b1;
                    trdy_d = 1'b1;
                    stop_d = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Purpose: register state and all bus drive values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            dev_q  <= 1'b1;
            trdy_q <= 1'b1;
            stop_q <= 1'b1;
            oe_q   <= 1'b0;
            rty_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            dev_q  <= dev_d;
            trdy_q <= trdy_d;
            stop_q <= stop_d;
            oe_q   <= oe_d;
            rty_q  <= rty_d;
        end
    end

    assign devsel_o_n = dev_q;
    assign trdy_o_n   = trdy_q;
    assign stop_o_n   = stop_q;
    assign resp_oe    = oe_q;
    assign busy       = (st_q != ST_IDLE);

    // R3
    claim_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && hit && !need_delay) |=> (resp_oe && !devsel_o_n));

    // R4
    hold_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && hit && need_delay) |=> !resp_oe ##1 (resp_oe && !devsel_o_n));

    // R7
    release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(resp_oe) |-> $past(devsel_o_n && trdy_o_n && stop_o_n));

    // R8
    ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!trdy_o_n && !stop_o_n));

    // R9
    busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BUSY && (frame_n || !devsel_n_in)) |=> !busy);

    // R11
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && !hit) |=> !resp_oe);
endmodule

// File: rtl/fb2b_target_trk.sv
// Top: back-to-back aware bus target tracker.
// Does: ties the window decoder, phase tracker and claim machine together
// and presents constant status bits.
// Assumes: bus lines are sampled on clk; resp_oe gates all three drivers.
module fb2b_target_trk
    import fb2b_pkg::*;
#(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] WIN_BASE = 32'h8000_0000,
    parameter logic [AW-1:0] WIN_MASK = 32'hFFFF_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_n,
    input  logic          irdy_n,
    input  logic          devsel_n_in,
    input  logic [AW-1:0] ad,
    input  logic          retry_req,
    output logic          devsel_o_n,
    output logic          trdy_o_n,
    output logic          stop_o_n,
    output logic          resp_oe,
    output logic          trk_busy,
    output logic          addr_seen,
    output logic          b2b_seen,
    output logic [AW-1:0] addr_q,
    output logic          stat_fb2b_cap,
    output logic [1:0]    stat_devsel_speed
);
    logic hit;
    logic addr_phase;
    logic fb2b;
    logic claimed_last;

    fb2b_addr_dec #(
        .AW(AW), .WIN_BASE(WIN_BASE), .WIN_MASK(WIN_MASK)
    ) u_dec (
        .ad  (ad),
        .hit (hit)
    );

    fb2b_phase_trk #(.AW(AW)) u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_n      (frame_n),
        .irdy_n       (irdy_n),
        .ad           (ad),
        .hit          (hit),
        .addr_phase   (addr_phase),
        .fb2b         (fb2b),
        .claimed_last (claimed_last),
        .addr_q       (addr_q),
        .addr_seen    (addr_seen),
        .b2b_seen     (b2b_seen)
    );

    fb2b_resp_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_n      (frame_n),
        .irdy_n       (irdy_n),
        .devsel_n_in  (devsel_n_in),
        .addr_phase   (addr_phase),
        .hit          (hit),
        .fb2b         (fb2b),
        .claimed_last (claimed_last),
        .retry_req    (retry_req),
        .devsel_o_n   (devsel_o_n),
        .trdy_o_n     (trdy_o_n),
        .stop_o_n     (stop_o_n),
        .resp_oe      (resp_oe),
        .busy         (trk_busy)
    );

    // R10: status is fixed, independent of any hold-off.
    assign stat_fb2b_cap     = 1'b1;
    assign stat_devsel_speed = DEVSEL_SPEED_FAST;

    // R2
    seen_marks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_seen |-> trk_busy);
endmodule

// File: tb/fb2b_target_trk_tb.sv
module fb2b_target_trk_tb;
    localparam int          AW        = 32;
    localparam logic [31:0] HIT_ADDR  = 32'h8000_1234;
    localparam logic [31:0] MISS_ADDR = 32'h4000_0010;
    localparam int          NV        = 19;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          frame_n, irdy_n, other_dev_n, retry_req;
    logic [AW-1:0] ad;
    logic          devsel_o_n, trdy_o_n, stop_o_n, resp_oe;
    logic          trk_busy, addr_seen, b2b_seen;
    logic [AW-1:0] addr_q;
    logic          stat_fb2b_cap;
    logic [1:0]    stat_devsel_speed;
    logic          devsel_bus;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    assign devsel_bus = other_dev_n & (resp_oe ? devsel_o_n : 1'b1);

    fb2b_target_trk u_dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .frame_n           (frame_n),
        .irdy_n            (irdy_n),
        .devsel_n_in       (devsel_bus),
        .ad                (ad),
        .retry_req         (retry_req),
        .devsel_o_n        (devsel_o_n),
        .trdy_o_n          (trdy_o_n),
        .stop_o_n          (stop_o_n),
        .resp_oe           (resp_oe),
        .trk_busy          (trk_busy),
        .addr_seen         (addr_seen),
        .b2b_seen          (b2b_seen),
        .addr_q            (addr_q),
        .stat_fb2b_cap     (stat_fb2b_cap),
        .stat_devsel_speed (stat_devsel_speed)
    );

    // Row: [15:12] requirement, then FRAME#, IRDY#, other DEVSEL#, retry, hit-address,
    // then expected {resp_oe, DEVSEL#, TRDY#, STOP#, busy, addr_seen, b2b_seen}.
    localparam logic [15:0] VEC [NV] = '{
        {4'd12, 5'b11100, 7'b0111000},  // R12 idle
        {4'd3,  5'b01101, 7'b1001110},  // R3 hit after Idle, claimed at once
        {4'd7,  5'b10100, 7'b1111100},  // R7 last phase -> drive high
        {4'd5,  5'b01101, 7'b1001111},  // R5 back-to-back to us, no hold
        {4'd7,  5'b00100, 7'b1001100},  // R7 FRAME# low: claim held
        {4'd7,  5'b10100, 7'b1111100},  // R7 turnaround
        {4'd2,  5'b01100, 7'b0111111},  // R2 back-to-back miss tracked
        {4'd9,  5'b00000, 7'b0111000},  // R9 other DEVSEL# ends tracking
        {4'd2,  5'b10000, 7'b0111000},  // R2 final data of foreign cycle
        {4'd6,  5'b01101, 7'b0111111},  // R6/R4 hold after foreign cycle
        {4'd4,  5'b10100, 7'b1001100},  // R4 claim one clock late
        {4'd7,  5'b10100, 7'b1111100},  // R7 turnaround
        {4'd7,  5'b11100, 7'b0111000},  // R7 release
        {4'd8,  5'b01111, 7'b1010110},  // R8 retry claim
        {4'd8,  5'b10100, 7'b1111100},  // R8 completes on STOP#
        {4'd7,  5'b11100, 7'b0111000},  // R7 release
        {4'd11, 5'b01100, 7'b0111110},  // R11 miss after Idle
        {4'd9,  5'b10100, 7'b0111000},  // R9 FRAME# high ends tracking
        {4'd12, 5'b11100, 7'b0111000}   // R12 idle again
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic f, input logic i, input logic d,
                         input logic r, input logic [AW-1:0] a);
        frame_n = f; irdy_n = i; other_dev_n = d; retry_req = r; ad = a;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [6:0] outs();
        return {resp_oe, devsel_o_n, trdy_o_n, stop_o_n, trk_busy, addr_seen, b2b_seen};
    endfunction

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b1, 1'b1, 1'b1, 1'b0, '0);
        repeat (3) tick();
        check("R12 reset outputs", 32'(outs()), 32'(7'b0111000));
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            drive(VEC[v][11], VEC[v][10], VEC[v][9], VEC[v][8],
                  VEC[v][7] ? HIT_ADDR : MISS_ADDR);
            tick();
            check($sformatf("R%0d row %0d", VEC[v][15:12], v),
                  32'(outs()), 32'(VEC[v][6:0]));
        end

        // R1: capture after Idle (miss)
        drive(1'b0, 1'b1, 1'b1, 1'b0, 32'h1357_2468);
        tick();
        check("R1 addr after idle", addr_q, 32'h1357_2468);
        check("R1 seen pulse", 32'({addr_seen, b2b_seen}), 32'(2'b10));
        drive(1'b1, 1'b0, 1'b1, 1'b0, '0);
        tick();
        // R1/R4: back-to-back hit captured, held off
        drive(1'b0, 1'b1, 1'b1, 1'b0, 32'h8000_55AA);
        tick();
        check("R1 addr back-to-back", addr_q, 32'h8000_55AA);
        check("R1 b2b pulse", 32'({addr_seen, b2b_seen}), 32'(2'b11));
        check("R4 hold cycle oe", 32'(resp_oe), 32'd0);
        // R10 during the hold
        check("R10 fb2b capable", 32'(stat_fb2b_cap), 32'd1);
        check("R10 decode speed", 32'(stat_devsel_speed), 32'd0);
        drive(1'b0, 1'b0, 1'b1, 1'b0, '0);
        tick();
        check("R4 late claim", 32'({resp_oe, devsel_o_n, trdy_o_n}), 32'(3'b100));
        // R12: reset in mid-claim
        rst_n = 1'b0;
        drive(1'b1, 1'b1, 1'b1, 1'b0, '0);
        tick();
        tick();
        check("R12 reset mid-claim", 32'(outs()), 32'(7'b0111000));
        rst_n = 1'b1;
        tick();
        check("R12 after release", 32'(outs()), 32'(7'b0111000));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule